// File: doc/BRIEF.md
# Maskable Device Interrupt Request Controller

This block owns the interrupt request of a task-file style storage device. The device's command sequencer asks for an interrupt with a one-cycle raise strobe and withdraws it with a clear strobe. The block also watches three host accesses, each as a one-cycle strobe:

- a read of the status register, together with the busy bit of the status value being returned;
- any write to the command register;
- a write to the device control register, together with the written byte.

A pending flag records whether an interrupt is owed to the host. It is kept apart from the interrupt line that the host sees. The line is the pending flag gated by the disable bit of the stored control byte. Masking therefore hides a request without losing it. Unmasking shows it again at once.

All inputs are plain level or strobe pins sampled on the rising clock edge. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. Every state change appears on the outputs one edge after the strobe that causes it.

When a raise strobe and any clearing event fall in the same cycle, the raise wins. This matches a command write that clears the old interrupt and then, in the same step, starts a command that asks for a new one.

Top module: `irq_mask_ctrl`

## Requirements
- R1: A raise strobe sets the pending flag at the next edge. A raise strobe while the flag is already set leaves the flag and the line unchanged.
- R2: A clear strobe from the device, without a raise in the same cycle, resets the pending flag and drops the line at the next edge, whether or not the line was masked.
- R3: A host status read whose returned busy bit is 0, without a raise in the same cycle, resets the pending flag at the next edge.
- R4: A host status read whose returned busy bit is 1 has no effect on the pending flag or the line.
- R5: A command-register write, without a raise in the same cycle, resets the pending flag at the next edge. A raise strobe in the same cycle as the command write leaves the flag set.
- R6: After every edge out of reset, the interrupt line equals the pending flag AND NOT control bit 1, where bit 1 is the interrupt-disable bit. The line is a register output.
- R7: A control write stores the whole written byte, which is visible on the control output after the next edge.
- R8: Writing the control byte with bit 1 set while an interrupt is pending drops the line at the next edge and keeps the pending flag. Writing it with bit 1 clear while pending re-asserts the line at the next edge.
- R9: While reset is active, the pending flag, the line and the stored control byte are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| dev_raise | input | 1 | Device asks for an interrupt (strobe) |
| dev_clear | input | 1 | Device withdraws its interrupt (strobe) |
| host_stat_rd | input | 1 | Host reads the status register (strobe) |
| host_stat_busy | input | 1 | Busy bit of the status value returned on that read |
| host_cmd_wr | input | 1 | Host writes the command register (strobe) |
| host_ctl_wr | input | 1 | Host writes the device control register (strobe) |
| host_ctl_wdata | input | CTL_W | Byte written to the control register |
| ctl_q | output | CTL_W | Stored control byte |
| irq_pending | output | 1 | Internal pending flag |
| irq_line | output | 1 | Interrupt line toward the host, active high |

## Verification
The assertions take for granted that every strobe is synchronous to the clock and that host_stat_busy is meaningful only in a cycle with host_stat_rd. They also take for granted that a raise in the same cycle as a clearing event is a legal request that should win. For this reason the clear properties are conditioned on no raise being present.

The stimulus drives each strobe for exactly one cycle, just after a falling edge. It holds the busy input at 0 except when it probes the busy read. It covers both orders of mask and raise, and it combines a raise with a command write in one cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Clearing events seen in one cycle.
  typedef struct packed {
    logic dev;    // clear strobe from the device sequencer
    logic stat;   // status read that returned busy = 0
    logic cmd;    // command register write
  } clr_ev_t;

  localparam int unsigned CLR_EV_W = $bits(clr_ev_t);

endpackage

// File: rtl/irq_clear_merge.sv
module irq_clear_merge
  import irq_pkg::*;
(
  input  logic    dev_clear,
  input  logic    stat_rd,
  input  logic    stat_busy,
  input  logic    cmd_wr,
  output clr_ev_t ev,
  output logic    clr_any
);

  logic [CLR_EV_W-1:0] ev_vec;

  always_comb begin
    ev.dev  = dev_clear;
    ev.stat = stat_rd & ~stat_busy;
    ev.cmd  = cmd_wr;
  end

  assign ev_vec = ev;

  // Any single event clears the flag.
  always_comb begin
    clr_any = 1'b0;
    for (int i = 0; i < CLR_EV_W; i++) begin
      clr_any = clr_any | ev_vec[i];
    end
  end

endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic clr_any,
  output logic pend_nxt,
  output logic pend_q
);

  // A raise in the same cycle as a clear wins.
  always_comb begin
    pend_nxt = pend_q;
    if (clr_any) pend_nxt = 1'b0;
    if (raise)   pend_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_nxt;
  end

endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg #(
  parameter int unsigned CTL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl_nxt,
  output logic [CTL_W-1:0] ctl_q
);

  assign ctl_nxt = wr ? wdata : ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_nxt;
  end

endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv #(
  parameter int unsigned CTL_W   = 8,
  parameter int unsigned DIS_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_nxt,
  input  logic [CTL_W-1:0] ctl_nxt,
  output logic             line_q
);

  localparam logic [CTL_W-1:0] DIS_MASK = CTL_W'(1) << DIS_BIT;

  logic masked_nxt;

  assign masked_nxt = |(ctl_nxt & DIS_MASK);

  // Built from the next-state values so that the line moves on the same
  // edge as the flag or the mask.
  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= pend_nxt & ~masked_nxt;
  end

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned CTL_W   = 8,
  parameter int unsigned DIS_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_raise,
  input  logic             dev_clear,
  input  logic             host_stat_rd,
  input  logic             host_stat_busy,
  input  logic             host_cmd_wr,
  input  logic             host_ctl_wr,
  input  logic [CTL_W-1:0] host_ctl_wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic             irq_pending,
  output logic             irq_line
);

  clr_ev_t          clr_ev;
  logic             clr_any;
  logic             pend_nxt;
  logic [CTL_W-1:0] ctl_nxt;
  logic [CLR_EV_W-1:0] clr_ev_unused;

  assign clr_ev_unused = clr_ev;

  irq_clear_merge u_clr (
    .dev_clear (dev_clear),
    .stat_rd   (host_stat_rd),
    .stat_busy (host_stat_busy),
    .cmd_wr    (host_cmd_wr),
    .ev        (clr_ev),
    .clr_any   (clr_any)
  );

  irq_pend_track u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .raise    (dev_raise),
    .clr_any  (clr_any),
    .pend_nxt (pend_nxt),
    .pend_q   (irq_pending)
  );

  irq_ctl_reg #(.CTL_W(CTL_W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (host_ctl_wr),
    .wdata   (host_ctl_wdata),
    .ctl_nxt (ctl_nxt),
    .ctl_q   (ctl_q)
  );

  irq_line_drv #(.CTL_W(CTL_W), .DIS_BIT(DIS_BIT)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_nxt (pend_nxt),
    .ctl_nxt  (ctl_nxt),
    .line_q   (irq_line)
  );

endmodule

// File: rtl/irq_mask_chk.sv
module irq_mask_chk #(
  parameter int unsigned CTL_W   = 8,
  parameter int unsigned DIS_BIT = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dev_raise,
  input logic             dev_clear,
  input logic             host_stat_rd,
  input logic             host_stat_busy,
  input logic             host_cmd_wr,
  input logic             host_ctl_wr,
  input logic [CTL_W-1:0] host_ctl_wdata,
  input logic [CTL_W-1:0] ctl_q,
  input logic             irq_pending,
  input logic             irq_line
);

  AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    dev_raise |=> irq_pending); // R1

  AST_DEV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_clear && !dev_raise) |=> (!irq_pending && !irq_line)); // R2

  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_stat_rd && !host_stat_busy && !dev_raise) |=> !irq_pending); // R3

  AST_BUSY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && host_stat_rd && host_stat_busy && !dev_clear && !host_cmd_wr)
      |=> irq_pending); // R4

  AST_CMD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cmd_wr && !dev_raise) |=> !irq_pending); // R5

  AST_LINE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line == (irq_pending && !ctl_q[DIS_BIT])); // R6

  AST_CTL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    host_ctl_wr |=> (ctl_q == $past(host_ctl_wdata))); // R7

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && host_ctl_wr && host_ctl_wdata[DIS_BIT]
      && !dev_clear && !host_cmd_wr && !(host_stat_rd && !host_stat_busy))
      |=> (irq_pending && !irq_line)); // R8

  AST_UNMASK_SHOW: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && host_ctl_wr && !host_ctl_wdata[DIS_BIT]
      && !dev_clear && !host_cmd_wr && !(host_stat_rd && !host_stat_busy))
      |=> irq_line); // R8

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |=> (!irq_pending && !irq_line && ctl_q == '0)); // R9

endmodule

bind irq_mask_ctrl irq_mask_chk #(.CTL_W(CTL_W), .DIS_BIT(DIS_BIT)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .dev_raise      (dev_raise),
  .dev_clear      (dev_clear),
  .host_stat_rd   (host_stat_rd),
  .host_stat_busy (host_stat_busy),
  .host_cmd_wr    (host_cmd_wr),
  .host_ctl_wr    (host_ctl_wr),
  .host_ctl_wdata (host_ctl_wdata),
  .ctl_q          (ctl_q),
  .irq_pending    (irq_pending),
  .irq_line       (irq_line)
);

// File: tb/sim_irq_mask_ctrl.sv
`timescale 1ns/1ps
module sim_irq_mask_ctrl;

  localparam int CTL_W = 8;

  typedef struct {
    logic             pend;
    logic             line;
    logic [CTL_W-1:0] ctl;
    string            tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             dev_raise = 1'b0, dev_clear = 1'b0;
  logic             host_stat_rd = 1'b0, host_stat_busy = 1'b0;
  logic             host_cmd_wr = 1'b0, host_ctl_wr = 1'b0;
  logic [CTL_W-1:0] host_ctl_wdata = '0;
  logic [CTL_W-1:0] ctl_q;
  logic             irq_pending, irq_line;

  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;
  exp_t sbq[$];

  // Bench model of the requirements
  logic             m_pend = 1'b0;
  logic [CTL_W-1:0] m_ctl  = '0;

  always #2.5 clk = ~clk;

  irq_mask_ctrl #(.CTL_W(CTL_W), .DIS_BIT(1)) u0 (
    .clk(clk), .rst_n(rst_n),
    .dev_raise(dev_raise), .dev_clear(dev_clear),
    .host_stat_rd(host_stat_rd), .host_stat_busy(host_stat_busy),
    .host_cmd_wr(host_cmd_wr), .host_ctl_wr(host_ctl_wr),
    .host_ctl_wdata(host_ctl_wdata),
    .ctl_q(ctl_q), .irq_pending(irq_pending), .irq_line(irq_line)
  );

  task automatic compare(input exp_t e);
    n_chk++;
    if (irq_pending !== e.pend || irq_line !== e.line || ctl_q !== e.ctl) begin
      n_err++;
      $display("FAIL %s: got pend=%0b line=%0b ctl=%02h, expected pend=%0b line=%0b ctl=%02h",
               e.tag, irq_pending, irq_line, ctl_q, e.pend, e.line, e.ctl);
    end
  endtask

  // Driver: one cycle of stimulus, then push the expected result
  task automatic step(input logic rs, input logic cl, input logic sr,
                      input logic sb, input logic cw, input logic kw,
                      input logic [CTL_W-1:0] kd, input string tag);
    exp_t e;
    @(negedge clk);
    dev_raise = rs; dev_clear = cl; host_stat_rd = sr; host_stat_busy = sb;
    host_cmd_wr = cw; host_ctl_wr = kw; host_ctl_wdata = kd;
    if (cl || (sr && !sb) || cw) m_pend = 1'b0;
    if (rs) m_pend = 1'b1;
    if (kw) m_ctl = kd;
    e.pend = m_pend;
    e.line = m_pend & ~m_ctl[1];
    e.ctl  = m_ctl;
    e.tag  = tag;
    sbq.push_back(e);
  endtask

  // Monitor: compare just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) compare(sbq.pop_front());
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    r.pend = 1'b0; r.line = 1'b0; r.ctl = '0; r.tag = "R9 reset";
    compare(r);
    rst_n = 1'b1;

    step(1,0,0,0,0,0,8'h00, "R1 raise unmasked");
    step(1,0,0,0,0,0,8'h00, "R1 second raise");
    step(0,0,0,0,0,0,8'h00, "R6 idle hold");
    step(0,0,1,1,0,0,8'h00, "R4 busy status read");
    step(0,0,1,0,0,0,8'h00, "R3 status read clears");
    step(1,0,0,0,0,0,8'h00, "R1 raise again");
    step(0,0,0,0,1,0,8'h00, "R5 command write clears");
    step(1,0,0,0,1,0,8'h00, "R5 raise beats command write");
    step(0,0,0,0,0,1,8'h02, "R8 mask drops line");
    step(1,0,0,0,0,0,8'h00, "R8 raise while masked");
    step(0,0,1,1,0,0,8'h00, "R4 busy read while masked");
    step(0,0,0,0,0,1,8'h00, "R8 unmask reasserts");
    step(0,1,0,0,0,0,8'h00, "R2 device clear");
    step(0,0,0,0,0,1,8'hFF, "R7 store all ones");
    step(1,0,0,0,0,0,8'h00, "R6 raise under mask");
    step(0,1,0,0,0,0,8'h00, "R2 clear while masked");
    step(0,0,0,0,0,1,8'hA5, "R7 store pattern");
    step(0,0,0,0,0,0,8'h00, "R2 no line after unmask");
    step(1,0,0,0,0,0,8'h00, "R6 raise with bit1 clear");
    step(0,1,0,0,0,1,8'h5A, "R2 clear with masking write");
    step(1,1,0,0,0,0,8'h00, "R2 raise beats clear");
    step(0,0,1,0,0,1,8'h00, "R3 read clears with unmask");
    step(0,0,0,0,0,0,8'h00, "R6 final idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule